// File: doc/BRIEF.md
# Chained Wide-Carry Multiply-Accumulate Sequencer

This block walks a short vector of 64-bit elements and runs one fused operation per element: it multiplies two operands, adds (or subtracts from) a third, and keeps the whole 128-bit result. The lower half of each result goes to a destination register. The upper half goes to a second destination. If the addend is a single fixed register and that register also receives the upper half, each element's upper half becomes the next element's addend. The row then forms a 64-bit carry chain, which is the inner step of schoolbook big-integer multiplication.

Operands live in a 32-entry internal register file. A write port and a read port let the surrounding logic preload values and collect results while the unit is idle. A start pulse captures four register indices, a scalar/vector flag for each of them, a vector length, a mode bit and an operation select. The unit then retires one element per clock in ascending element order and pulses `done` once. Decode, quotient estimation and any fusion detection sit outside this block.

Top module: `vmac_chain`

## Requirements
- R1: After reset every register file entry reads zero and `busy` and `done` are low.
- R2: With `op_sub`=0, each element forms the 128-bit value A*B+C from 64-bit operands. Bits [63:0] go to the low destination and bits [127:64] go to the high destination. No result overflows, and no carry flag exists.
- R3: The index used for element e is `base + e` (modulo 32) when the operand's vector flag is 1, and `base` when the flag is 0. This holds independently for A, B, C and the low destination.
- R4: With `hi_to_c`=1 the high destination is element e's C index, so the addend is overwritten. With `hi_to_c`=0 it is element e's low-destination index plus the effective vector length (modulo 32), and C is left unchanged.
- R5: With scalar C and `hi_to_c`=1, each element's high half becomes the next element's addend, giving a 64-bit carry chain across the row.
- R6: With `op_sub`=1, each element forms C − A*B modulo 2^128 in two's complement. The low half and high half go to the same destinations as in R2.
- R7: A start accepted while idle with effective length L≥1 sets `busy` for exactly L cycles and writes one element per cycle. `done` is high for the single cycle after the last element is written. With L=0, `done` pulses in the cycle after start, `busy` stays low and nothing is written.
- R8: A requested vector length above 8 is treated as 8.
- R9: If both destinations of an element are the same index, the high half is stored. A register written by element e is seen by element e+1 when it reads.
- R10: While `busy` is high, `start` and host writes are ignored. The running operation and the register contents are unaffected.
- R11: `host_rdata` shows the register selected by `host_ridx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (taken only when idle) |
| vl | input | 4 | Requested vector length, 0 to 15, clamped to 8 |
| ra_idx | input | 5 | Base index of multiplicand A |
| rb_idx | input | 5 | Base index of multiplier B |
| rc_idx | input | 5 | Base index of addend C |
| rt_idx | input | 5 | Base index of the low-half destination |
| ra_vec | input | 1 | A steps per element when 1 |
| rb_vec | input | 1 | B steps per element when 1 |
| rc_vec | input | 1 | C steps per element when 1 |
| rt_vec | input | 1 | Low destination steps per element when 1 |
| hi_to_c | input | 1 | 1: high half to C index; 0: high half to low index + length |
| op_sub | input | 1 | 0: A*B+C; 1: C−A*B |
| busy | output | 1 | An operation is stepping through elements |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host write enable (idle only) |
| host_widx | input | 5 | Host write index |
| host_wdata | input | 64 | Host write data |
| host_ridx | input | 5 | Host read index |
| host_rdata | output | 64 | Host read data |

## Verification
On every cycle the bound checker checks four things: the done pulse arrives after exactly as many busy cycles as the clamped length captured at start, a done pulse is never followed by a second one unless a zero-length start caused it, the high destination equals the addend index in addend-overwrite mode, and a scalar A never moves. The arithmetic itself has to be shown by the bench's scenarios. These cover carry propagation along a scalar-addend chain, all-ones operands, subtract wraparound, index wrap past 31, the collision where both destinations are the same register, and starts and host writes injected mid-run. A behavioural model predicts the outcome of each scenario, and every register is then read back.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
    localparam int XLEN  = 64;
    localparam int NREG  = 32;
    localparam int IDXW  = $clog2(NREG);
    localparam int VLMAX = 8;
    localparam int VLW   = $clog2(VLMAX) + 1;

    typedef logic [IDXW-1:0] ridx_t;
    typedef logic [XLEN-1:0] word_t;
    typedef logic [VLW-1:0]  vlen_t;

    typedef struct packed {
        ridx_t a;
        ridx_t b;
        ridx_t c;
        ridx_t t;
        logic  va;
        logic  vb;
        logic  vc;
        logic  vt;
        logic  hi_to_c;
        logic  sub;
        vlen_t vl;
    } cfg_t;

    typedef enum logic {ST_IDLE, ST_RUN} state_t;

    typedef struct packed {
        state_t st;
        vlen_t  elem;
        cfg_t   cfg;
        logic   done;
    } seq_t;
endpackage

// File: rtl/vmac_agu.sv
module vmac_agu
    import vmac_pkg::*;
(
    input  cfg_t  cfg,
    input  vlen_t elem,
    output ridx_t a_idx,
    output ridx_t b_idx,
    output ridx_t c_idx,
    output ridx_t t_idx,
    output ridx_t hi_idx
);
    function automatic ridx_t step(input ridx_t base, input logic vec, input vlen_t e);
        logic [IDXW:0] sum;
        sum = {1'b0, base} + (vec ? (IDXW+1)'(e) : '0);
        return sum[IDXW-1:0];
    endfunction

    always_comb begin
        a_idx  = step(cfg.a, cfg.va, elem);
        b_idx  = step(cfg.b, cfg.vb, elem);
        c_idx  = step(cfg.c, cfg.vc, elem);
        t_idx  = step(cfg.t, cfg.vt, elem);
        hi_idx = cfg.hi_to_c ? c_idx : step(t_idx, 1'b1, cfg.vl);
    end
endmodule

// File: rtl/vmac_mac.sv
module vmac_mac
    import vmac_pkg::*;
(
    input  word_t a,
    input  word_t b,
    input  word_t c,
    input  logic  sub,
    output word_t lo,
    output word_t hi
);
    localparam int PW = 2 * XLEN;
    logic [PW-1:0] prod;
    logic [PW-1:0] addend;
    logic [PW-1:0] res;

    always_comb begin
        prod   = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
        addend = {{XLEN{1'b0}}, c};
        res    = sub ? (addend - prod) : (prod + addend);
        lo     = res[XLEN-1:0];
        hi     = res[PW-1:XLEN];
    end
endmodule

// File: rtl/vmac_rf.sv
module vmac_rf
    import vmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ridx_t ra,
    input  ridx_t rb,
    input  ridx_t rc,
    output word_t da,
    output word_t db,
    output word_t dc,
    input  ridx_t rh,
    output word_t dh,
    input  logic  we_lo,
    input  ridx_t wi_lo,
    input  word_t wd_lo,
    input  logic  we_hi,
    input  ridx_t wi_hi,
    input  word_t wd_hi,
    input  logic  we_h,
    input  ridx_t wi_h,
    input  word_t wd_h
);
    word_t mem_q [NREG];
    word_t mem_d [NREG];

    always_comb begin
        mem_d = mem_q;
        if (we_h)  mem_d[wi_h]  = wd_h;
        if (we_lo) mem_d[wi_lo] = wd_lo;
        if (we_hi) mem_d[wi_hi] = wd_hi;   // high half wins a shared index
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign da = mem_q[ra];
    assign db = mem_q[rb];
    assign dc = mem_q[rc];
    assign dh = mem_q[rh];
endmodule

// File: rtl/vmac_chain.sv
module vmac_chain
    import vmac_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VLW-1:0]  vl,
    input  logic [IDXW-1:0] ra_idx,
    input  logic [IDXW-1:0] rb_idx,
    input  logic [IDXW-1:0] rc_idx,
    input  logic [IDXW-1:0] rt_idx,
    input  logic            ra_vec,
    input  logic            rb_vec,
    input  logic            rc_vec,
    input  logic            rt_vec,
    input  logic            hi_to_c,
    input  logic            op_sub,
    output logic            busy,
    output logic            done,
    input  logic            host_we,
    input  logic [IDXW-1:0] host_widx,
    input  logic [XLEN-1:0] host_wdata,
    input  logic [IDXW-1:0] host_ridx,
    output logic [XLEN-1:0] host_rdata
);
    seq_t  r_q, r_d;
    vlen_t vl_eff;
    ridx_t a_idx, b_idx, c_idx, t_idx, hi_idx;
    word_t da, db, dc, lo_val, hi_val;
    logic  running;
    logic  host_ok;

    assign vl_eff  = (vl > VLW'(VLMAX)) ? VLW'(VLMAX) : vl;
    assign running = (r_q.st == ST_RUN);
    assign host_ok = host_we && !running;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.cfg  = '{a: ra_idx, b: rb_idx, c: rc_idx, t: rt_idx,
                                 va: ra_vec, vb: rb_vec, vc: rc_vec, vt: rt_vec,
                                 hi_to_c: hi_to_c, sub: op_sub, vl: vl_eff};
                    r_d.elem = '0;
                    if (vl_eff == '0) r_d.done = 1'b1;
                    else              r_d.st   = ST_RUN;
                end
            end
            ST_RUN: begin
                if (r_q.elem == r_q.cfg.vl - 1'b1) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.elem = r_q.elem + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    vmac_agu u_agu (
        .cfg(r_q.cfg), .elem(r_q.elem),
        .a_idx(a_idx), .b_idx(b_idx), .c_idx(c_idx), .t_idx(t_idx), .hi_idx(hi_idx)
    );

    vmac_mac u_mac (
        .a(da), .b(db), .c(dc), .sub(r_q.cfg.sub), .lo(lo_val), .hi(hi_val)
    );

    vmac_rf u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra(a_idx), .rb(b_idx), .rc(c_idx),
        .da(da), .db(db), .dc(dc),
        .rh(host_ridx), .dh(host_rdata),
        .we_lo(running), .wi_lo(t_idx),  .wd_lo(lo_val),
        .we_hi(running), .wi_hi(hi_idx), .wd_hi(hi_val),
        .we_h(host_ok),  .wi_h(host_widx), .wd_h(host_wdata)
    );

    assign busy = running;
    assign done = r_q.done;
endmodule

// File: rtl/vmac_chain_chk.sv
module vmac_chain_chk
    import vmac_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  start,
    input vlen_t vl,
    input logic  busy,
    input logic  done,
    input logic  hi_to_c,
    input ridx_t hi_idx,
    input ridx_t c_idx,
    input logic  va,
    input ridx_t a_idx,
    input ridx_t a_base
);
    vlen_t cap_q, cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            cnt_q <= '0;
        end else if (start && !busy) begin
            cap_q <= (vl > VLW'(VLMAX)) ? VLW'(VLMAX) : vl;
            cnt_q <= '0;
        end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7: done arrives after exactly the captured number of busy cycles
    a_r7_done_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == cap_q));

    // R7: done is a single-cycle pulse unless a zero-length start follows it
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(start && vl == '0)) |=> !done);

    // R4: in addend-overwrite mode the high half lands on the C index
    a_r4_hi_on_c: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hi_to_c) |-> (hi_idx == c_idx));

    // R3: a scalar A operand never moves during a run
    a_r3_scalar_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !va) |-> (a_idx == a_base));
endmodule

bind vmac_chain vmac_chain_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .busy(busy), .done(done),
    .hi_to_c(r_q.cfg.hi_to_c), .hi_idx(hi_idx), .c_idx(c_idx),
    .va(r_q.cfg.va), .a_idx(a_idx), .a_base(r_q.cfg.a)
);

// File: tb/vmac_chain_tb.sv
`timescale 1ns/1ps
module vmac_chain_tb;
    logic        clk = 0, rst_n = 0, start = 0;
    logic [3:0]  vl = 0;
    logic [4:0]  ra_idx = 0, rb_idx = 0, rc_idx = 0, rt_idx = 0;
    logic        ra_vec = 0, rb_vec = 0, rc_vec = 0, rt_vec = 0, hi_to_c = 0, op_sub = 0;
    logic        busy, done, host_we = 0;
    logic [4:0]  host_widx = 0, host_ridx = 0;
    logic [63:0] host_wdata = 0, host_rdata;

    logic [63:0] model [32];
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    vmac_chain u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input int idx, input logic [63:0] d);
        @(negedge clk);
        host_we = 1; host_widx = 5'(idx); host_wdata = d;
        @(posedge clk); #1 host_we = 0;
        model[idx] = d;
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            host_ridx = 5'(i);
            #1 chk(host_rdata == model[i], req, host_rdata, model[i]);
        end
    endtask

    task automatic run_op(input int a, b, c, t, input bit va, vb, vc, vt, input bit hc, sb,
                          input int len, input bit inject, input string req);
        int veff;
        veff = (len > 8) ? 8 : len;
        @(negedge clk);
        ra_idx = 5'(a); rb_idx = 5'(b); rc_idx = 5'(c); rt_idx = 5'(t);
        ra_vec = va; rb_vec = vb; rc_vec = vc; rt_vec = vt;
        hi_to_c = hc; op_sub = sb; vl = 4'(len); start = 1;
        @(posedge clk); #1 start = 0;
        for (int e = 0; e < veff; e++) begin
            logic [127:0] p;
            logic [63:0]  xa, xb, xc;
            int ia, ib, ic, it, ih;
            @(negedge clk);
            chk(busy == 1 && done == 0, "R7 busy", {busy, done}, 2'b10);
            ia = (a + (va ? e : 0)) % 32; ib = (b + (vb ? e : 0)) % 32;
            ic = (c + (vc ? e : 0)) % 32; it = (t + (vt ? e : 0)) % 32;
            ih = hc ? ic : (it + veff) % 32;
            xa = model[ia]; xb = model[ib]; xc = model[ic];
            p  = sb ? ({64'd0, xc} - {64'd0, xa} * {64'd0, xb})
                    : ({64'd0, xa} * {64'd0, xb} + {64'd0, xc});
            model[it] = p[63:0];
            model[ih] = p[127:64];
            if (inject && e == 1) begin
                // R10: a start and a host write while busy must be ignored
                start = 1; vl = 4'd1; rt_idx = 5'd31; rt_vec = 0;
                host_we = 1; host_widx = 5'd30; host_wdata = 64'hdead_beef_dead_beef;
            end
            @(posedge clk); #1 start = 0; host_we = 0;
        end
        @(negedge clk);
        chk(busy == 0 && done == 1, {req, " R7 done"}, {busy, done}, 2'b01);
        @(negedge clk);
        chk(done == 0, "R7 single pulse", done, 0);
        readback(req);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset state
        chk(busy == 0 && done == 0, "R1 flags", {busy, done}, 0);
        readback("R1/R11 reset contents");

        for (int i = 0; i < 16; i++)
            hwrite(i, {32'(i) * 32'h9e37_79b9 + 32'h1357, 32'(i) * 32'h7f4a_7c15 ^ 32'hffff_0f0f});
        hwrite(16, 64'd0);
        hwrite(17, 64'hfedc_ba98_7654_3210);

        // R5: scalar-C carry chain, A vector, B scalar, T vector
        run_op(8, 17, 16, 0, 1, 0, 0, 1, 1, 0, 4, 0, "R5 carry chain");

        // R2: all-ones operands; high half to T+VL
        hwrite(1, '1); hwrite(2, '1); hwrite(3, '1);
        run_op(1, 2, 3, 4, 0, 0, 0, 0, 0, 0, 1, 0, "R2 all-ones");

        // R4: T+VL mode with vector C, C left intact
        run_op(8, 9, 12, 20, 1, 1, 1, 1, 0, 0, 3, 0, "R4 rt+vl mode");

        // R6: multiply-subtract with wraparound
        hwrite(16, 64'd5);
        run_op(10, 17, 16, 24, 1, 0, 0, 1, 1, 1, 2, 0, "R6 mul-sub");

        // R7: zero length does nothing but pulse done
        @(negedge clk);
        vl = 0; start = 1; rt_idx = 5'd2;
        @(posedge clk); #1 start = 0;
        @(negedge clk);
        chk(done == 1 && busy == 0, "R7 zero length done", {busy, done}, 2'b01);
        @(negedge clk);
        chk(done == 0, "R7 zero length pulse", done, 0);
        readback("R7 zero length no writes");

        // R8/R3: oversized length clamps, T index wraps past 31
        run_op(0, 17, 16, 28, 1, 0, 0, 1, 1, 0, 12, 0, "R8 clamp R3 wrap");

        // R9: both destinations share one register; high half wins
        run_op(8, 9, 16, 16, 1, 0, 0, 0, 1, 0, 3, 0, "R9 shared dest");

        // R10: start and host write ignored while busy
        run_op(4, 5, 6, 12, 1, 1, 1, 1, 0, 0, 4, 1, "R10 busy ignores");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule